// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The RAM has two chip enables of opposite polarity, an output enable, an active-low write enable and one shared data bus. The host offers a single access at a time through a request/ready handshake. It gives a 17-bit address, a write flag and a write byte, and reads come back as a byte with a one-cycle valid strobe. The controller turns each accepted request into a sequence of clock-counted phases. Each phase length comes from a minimum RAM time divided by the clock period, rounded up, and is never less than one cycle.

The sequencer has six states. `ST_IDLE` keeps the RAM deselected and is the only state that accepts a request. A read runs `ST_IDLE -> ST_RD_ACCESS -> ST_RD_FLOAT -> ST_IDLE`. A write runs `ST_IDLE -> ST_WR_SETUP -> ST_WR_PULSE -> ST_WR_HOLD -> ST_IDLE`. Every non-idle state leaves when its phase counter expires. Read data is sampled on the edge that ends `ST_RD_ACCESS`. `ST_RD_FLOAT` then keeps the RAM deselected long enough for its outputs to stop driving before the controller can drive the bus.

The data bus is split into an output, an output-enable and an input, so that a pad ring or a board-level model can join them.

Top module: `sram_ctrl`

## Requirements
- R1: During reset, and in `ST_IDLE`, the RAM pins are held in standby: enable-1 high, enable-2 low, write enable high, output enable high, bus not driven. `ready` is high in `ST_IDLE`. An asynchronous reset forces standby at once, even in the middle of an access.
- R2: A request is taken on a clock edge where `req` and `ready` are both high. `ready` stays low from that edge until the sequence returns to `ST_IDLE`, which lasts at least one cycle before the next request is taken.
- R3: A read holds both enables asserted, output enable low and write enable high for RD = max(ceil(tAA/tCLK), ceil(tRC/tCLK), 1) cycles. With the default timing this is 7 cycles. The address stays constant for the whole access.
- R4: The read byte is sampled on the edge that ends the access phase. `rvalid` is high for exactly the following cycle, with `rdata` equal to the byte stored at that address. Output enable rises only after that sample.
- R5: After a read, the RAM stays deselected with output enable high for TA = max(ceil(tHZ/tCLK), 1) cycles before `ST_IDLE`. With the default timing this is 2 cycles.
- R6: A write begins with one setup cycle: enables asserted, write enable high, output enable high, bus not driven.
- R7: The write pulse holds write enable low for WP = max(ceil(tPWE/tCLK), ceil(tSD/tCLK), ceil(tAW/tCLK), ceil(tWC/tCLK)-2, 1) cycles. With the default timing this is 5 cycles. The controller drives the write byte on the bus for the whole pulse, and the byte and address do not change during it.
- R8: The write ends with one hold cycle: write enable high, enables still asserted, byte still driven. The controller then deselects the RAM and releases the bus.
- R9: Output enable is never low while write enable is low or while the controller drives the bus. The controller never drives the bus while the RAM may still be driving it.
- R10: A byte written to an address is returned by later reads of that address. Other addresses keep their contents.
- R11: `rvalid` is never raised by a write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host address |
| req_wdata | input | 8 | Host write byte |
| ready | output | 1 | Controller idle, request can be taken |
| rvalid | output | 1 | Read byte valid (one cycle) |
| rdata | output | 8 | Read byte |
| sram_addr | output | 17 | RAM address |
| sram_ce1_n | output | 1 | RAM enable 1, active low |
| sram_ce2 | output | 1 | RAM enable 2, active high |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Byte driven to the RAM bus |
| sram_dq_oe | output | 1 | Controller drives the RAM bus |
| sram_dq_i | input | 8 | Byte read from the RAM bus |

## Verification
Accesses are tried in several orders: writes back to back, reads back to back, a read followed by a write, and a write followed by a read of the same address. The read-then-write order shows whether the float phase is kept before the bus is driven. The write-then-read order shows whether hold and deselect complete before the output is enabled. Data patterns 00, FF, 55, AA and walking values at the lowest, highest and alternating-bit addresses separate a correct write from a stuck or mixed-up data or address bit, and a read of a never-written location separates a true read from a stale byte. The RAM model returns the inverse of the byte until the access time has passed, so sampling one cycle early is visible. It also measures each write pulse and data setup in 100 ps steps and flags any overlap of the two bus drivers. A reset in the middle of a read shows that standby is entered at once.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_STANDBY = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Cycles needed to cover a minimum time, never below one.
    function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC = 7,
    parameter int unsigned WP_CYC = 5,
    parameter int unsigned TA_CYC = 2,
    parameter int unsigned CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             tmr_done,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pins_t            pins
);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

    seq_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (req) st_d = req_we ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (tmr_done) st_d = ST_RD_FLOAT;
            ST_RD_FLOAT:  if (tmr_done) st_d = ST_IDLE;
            ST_WR_SETUP:  if (tmr_done) st_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (tmr_done) st_d = ST_WR_HOLD;
            ST_WR_HOLD:   if (tmr_done) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Phase length loaded on entry to each state
    always_comb begin
        unique case (st_d)
            ST_RD_ACCESS: tmr_val = RD_LAST;
            ST_RD_FLOAT:  tmr_val = TA_LAST;
            ST_WR_PULSE:  tmr_val = WP_LAST;
            default:      tmr_val = '0;
        endcase
    end

    assign tmr_load = (st_d != st_q);
    assign ready    = (st_q == ST_IDLE);
    assign accept   = ready && req;
    assign capture  = (st_q == ST_RD_ACCESS) && tmr_done;

    function automatic pins_t decode(input seq_state_e s);
        pins_t p;
        p = PINS_STANDBY;
        unique case (s)
            ST_RD_ACCESS: begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.oe_n = 1'b0; end
            ST_WR_SETUP:  begin p.ce1_n = 1'b0; p.ce2 = 1'b1; end
            ST_WR_PULSE:  begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.we_n = 1'b0; p.drive = 1'b1; end
            ST_WR_HOLD:   begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.drive = 1'b1; end
            default:      p = PINS_STANDBY;
        endcase
        return p;
    endfunction

    // Registered pin outputs, glitch free toward the RAM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins <= PINS_STANDBY;
        else        pins <= decode(st_d);
    end

    // ---------------- checker state and assertions ----------------
    localparam int unsigned CHK_W = CNT_W + 1;
    localparam logic [CHK_W-1:0] WP_MIN = CHK_W'(WP_CYC);
    localparam logic [CHK_W-1:0] TA_MIN = CHK_W'(TA_CYC);

    logic [CHK_W-1:0] we_low_cnt;
    logic [CHK_W-1:0] float_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            float_cnt  <= TA_MIN;
        end else begin
            if (!pins.we_n) begin
                if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
            end else begin
                we_low_cnt <= '0;
            end
            if (!pins.oe_n)              float_cnt <= '0;
            else if (float_cnt < TA_MIN) float_cnt <= float_cnt + 1'b1;
        end
    end

    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pins == PINS_STANDBY));

    a_r9_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins.we_n || pins.drive) |-> pins.oe_n);

    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.we_n) |-> (we_low_cnt >= WP_MIN));

    a_r5_float_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        pins.drive |-> (float_cnt >= TA_MIN));

    a_r2_ready_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              ready,
    input  logic              drive,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_addr <= '0;
            dq_o      <= '0;
        end else if (accept) begin
            sram_addr <= req_addr;
            dq_o      <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_i;
        end
    end

    a_r4_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && $past(drive)) |-> $stable(dq_o));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(sram_addr));

    a_r11_no_rvalid_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> !rvalid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_CLK_PS = 5000,
    parameter int unsigned T_AA_PS  = 35000,
    parameter int unsigned T_RC_PS  = 35000,
    parameter int unsigned T_WC_PS  = 35000,
    parameter int unsigned T_PWE_PS = 25000,
    parameter int unsigned T_AW_PS  = 25000,
    parameter int unsigned T_SD_PS  = 20000,
    parameter int unsigned T_HZ_PS  = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int unsigned WC_CYC  = cycles_for(T_WC_PS, T_CLK_PS);
    localparam int unsigned WC_BODY = (WC_CYC > 2) ? (WC_CYC - 2) : 1;
    localparam int unsigned RD_CYC  = max2(cycles_for(T_AA_PS, T_CLK_PS), cycles_for(T_RC_PS, T_CLK_PS));
    localparam int unsigned WP_CYC  = max2(max2(cycles_for(T_PWE_PS, T_CLK_PS), cycles_for(T_SD_PS, T_CLK_PS)),
                                           max2(cycles_for(T_AW_PS, T_CLK_PS), WC_BODY));
    localparam int unsigned TA_CYC  = cycles_for(T_HZ_PS, T_CLK_PS);
    localparam int unsigned MAX_LEN = max2(RD_CYC, max2(WP_CYC, TA_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic             accept, capture, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    pins_t            pins;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .tmr_done (tmr_done),
        .ready    (ready),
        .accept   (accept),
        .capture  (capture),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .pins     (pins)
    );

    sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .ready     (ready),
        .drive     (pins.drive),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_i      (sram_dq_i),
        .sram_addr (sram_addr),
        .dq_o      (sram_dq_o),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    assign sram_ce1_n = pins.ce1_n;
    assign sram_ce2   = pins.ce2;
    assign sram_we_n  = pins.we_n;
    assign sram_oe_n  = pins.oe_n;
    assign sram_dq_oe = pins.drive;

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

    // Phase lengths worked out from the requirements at 5 ns clock
    localparam int RD = 7;   // R3: ceil(35/5)
    localparam int WP = 5;   // R7: max(5,4,5,7-2)
    localparam int TA = 2;   // R5: ceil(10/5)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic [16:0] sram_addr;
    logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_o;
    logic [7:0]  sram_dq_i = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2500ps clk = ~clk;

    sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- timing-checking RAM model (100 ps steps) ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    int  tick = 0, wr_start = 0, data_tick = 0, acc_tick = 0, float_end = 0;
    bit  wr_prev = 0, rd_prev = 0, cont_seen = 0;
    int  cont_cnt = 0;
    logic [8:0]  bus_prev = '0;
    logic [16:0] addr_prev = '0, wr_addr = '0;

    function automatic logic [7:0] mrd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    initial begin
        #50ps;
        forever begin
            bit sel, wr_on, rd_on;
            tick++;
            sel   = !sram_ce1_n && sram_ce2;
            wr_on = sel && !sram_we_n;
            rd_on = sel && sram_we_n && !sram_oe_n;
            if ({sram_dq_oe, sram_dq_o} != bus_prev) data_tick = tick;
            bus_prev = {sram_dq_oe, sram_dq_o};
            if (wr_on && !wr_prev) begin
                wr_start = tick;
                wr_addr  = sram_addr;
            end
            if (wr_on && sram_addr != wr_addr)
                chk(1'b0, "R7 address moved during write", sram_addr, wr_addr);
            if (!wr_on && wr_prev) begin
                chk((tick - wr_start) >= 250, "R7 write pulse >= 25ns (ticks)", tick - wr_start, 250);
                chk(sram_dq_oe && (tick - data_tick) >= 200, "R7 data setup >= 20ns (ticks)", tick - data_tick, 200);
                mem[int'(wr_addr)] = sram_dq_o;
            end
            if (rd_on && (!rd_prev || sram_addr != addr_prev)) acc_tick = tick;
            if (!rd_on && rd_prev) float_end = tick + 100;
            sram_dq_i = rd_on ? (((tick - acc_tick) >= 349) ? mrd(int'(sram_addr)) : ~mrd(int'(sram_addr))) : 8'h00;
            if (sram_dq_oe && (rd_on || tick < float_end)) begin
                cont_cnt++;
                if (!cont_seen) begin
                    cont_seen = 1;
                    $display("FAIL R9 bus contention actual=1 expected=0 at %0t", $time);
                end
            end
            wr_prev   = wr_on;
            rd_prev   = rd_on;
            addr_prev = sram_addr;
            #100ps;
        end
    end

    // ---------------- cycle reference model ----------------
    // entry: {phase[2:0], ce1_n, ce2, oe_n, we_n, drive, rvalid}
    // phase 1 read access, 2 float, 3 write setup, 4 write pulse, 5 write hold
    logic [8:0] exp_q [$];
    logic [16:0] cur_addr;
    logic [7:0]  cur_data;

    function automatic string ptag(input logic [2:0] ph);
        case (ph)
            3'd1: return "R3 read access pins";
            3'd2: return "R5 float pins";
            3'd3: return "R6 write setup pins";
            3'd4: return "R7 write pulse pins";
            default: return "R8 write hold pins";
        endcase
    endfunction

    task automatic compare_step();
        logic [8:0] e;
        logic [5:0] act;
        e = exp_q.pop_front();
        act = {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, rvalid};
        chk(act == e[5:0], ptag(e[8:6]), {26'd0, act}, {26'd0, e[5:0]});
        chk(ready == 1'b0, "R2 ready low while busy", ready, 0);
        if (!e[5]) chk(sram_addr == cur_addr, "R3 address held", sram_addr, cur_addr);
        if (e[1])  chk(sram_dq_o == cur_data, "R7 driven byte", sram_dq_o, cur_data);
        if (e[0])  chk(rdata == cur_data, "R4 R10 read byte", rdata, cur_data);
        if (e[8:6] == 3'd4 || e[8:6] == 3'd5) chk(!rvalid, "R11 no rvalid on write", rvalid, 0);
    endtask

    task automatic check_idle();
        chk({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe} == 5'b10110,
            "R1 idle standby pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
        chk(ready == 1'b1, "R1 ready in idle", ready, 1);
        chk(rvalid == 1'b0, "R1 no rvalid in idle", rvalid, 0);
    endtask

    task automatic op(input bit we, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        check_idle();
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        cur_addr = a;
        if (we) begin
            cur_data = d;
            shadow[int'(a)] = d;
            exp_q.push_back({3'd3, 6'b011100});
            for (int i = 0; i < WP; i++) exp_q.push_back({3'd4, 6'b011010});
            exp_q.push_back({3'd5, 6'b011110});
        end else begin
            cur_data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
            for (int i = 0; i < RD; i++) exp_q.push_back({3'd1, 6'b010100});
            exp_q.push_back({3'd2, 6'b101101});
            for (int i = 1; i < TA; i++) exp_q.push_back({3'd2, 6'b101100});
        end
        @(negedge clk);
        req = 1'b0;
        req_wdata = ~d;
        req_addr  = ~a;
        compare_step();
        while (exp_q.size() > 0) begin
            @(negedge clk);
            compare_step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe} == 5'b10110,
            "R1 standby during reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
        chk(rvalid == 1'b0, "R1 rvalid low in reset", rvalid, 0);
        rst_n = 1'b1;

        // writes back to back at corner addresses and patterns
        op(1, 17'h00000, 8'h5A);
        op(1, 17'h1FFFF, 8'hA5);
        op(1, 17'h0AAAA, 8'hFF);
        op(1, 17'h15555, 8'h00);
        op(1, 17'h00001, 8'h3C);
        // reads back to back (R10)
        op(0, 17'h00000, 8'h00);
        op(0, 17'h1FFFF, 8'h00);
        op(0, 17'h0AAAA, 8'h00);
        op(0, 17'h15555, 8'h00);
        op(0, 17'h00001, 8'h00);
        op(0, 17'h12345, 8'h00);   // never written
        // read followed by write (R5 turnaround), then read back
        op(1, 17'h00000, 8'hC3);
        op(0, 17'h00000, 8'h00);
        op(0, 17'h00001, 8'h00);   // neighbour unchanged
        // walking bytes on walking addresses, write then read
        for (int i = 0; i < 17; i++) begin
            op(1, 17'(1 << i), 8'(8'h01 << (i % 8)) ^ 8'h80);
            op(0, 17'(1 << i), 8'h00);
        end
        op(0, 17'h1FFFF, 8'h00);

        // reset in the middle of a read (R1)
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 17'h00010;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #100ps;
        chk({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe} == 5'b10110,
            "R1 standby forced by reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        op(1, 17'h00010, 8'h96);
        op(0, 17'h00010, 8'h00);

        repeat (3) @(negedge clk);
        chk(cont_cnt == 0, "R9 no bus contention over run", cont_cnt, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000ns;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule